// File: doc/BRIEF.md
# ALU and Shifter Execution Unit

This block is the combinational execution stage of a small 16-bit processor. A 5-bit opcode and two operands, `opnd_a` and `opnd_b`, go in; a result word and three status outputs come out in the same cycle: a zero flag, a carry/borrow flag and an illegal-opcode indication. Arithmetic and logic operations occupy codes starting with `0`, and single-bit shifts and rotates occupy codes starting with `10`.

Inside, a decoder sorts the opcode into one of five unit classes: logic, arithmetic, shift, clear or none. Each class has a function code. The three datapath units work in parallel, and a final select picks the class result and its carry. The decoder's classes play the role of named states. The decode "transitions" are opcode to class: LOGIC, ARITH, SHIFT, CLEAR, NONE. No clocked state is kept. Register storage and operand fetch belong to the surrounding pipeline.

Top module: `alu_shift_exec`

## Requirements
- R1: Opcode 01001 gives a AND b, 01010 gives a OR b, 01011 gives a XOR b; all three clear the carry flag.
- R2: Opcode 01100 gives the bitwise inverse of a with carry cleared; the value of b has no effect on any output.
- R3: Opcode 01101 gives the low 16 bits of a + b, with the carry flag set to the carry out of bit 15.
- R4: Opcode 01110 gives a − b modulo 2^16, with the carry flag set exactly when a < b (borrow).
- R5: Opcode 00111 gives a + 1, with carry set only when a = 0xFFFF. Opcode 01000 gives a − 1, with carry set only when a = 0x0000.
- R6: Opcode 01111 gives a result of 0x0000 with carry cleared, whatever a and b are.
- R7: Opcode 10000 shifts a left by one and opcode 10001 shifts a right by one. The vacated bit is 0, and the carry flag takes the bit shifted out (a[15] for left, a[0] for right).
- R8: Opcode 10010 rotates a right by one (a[0] moves to bit 15) and 10011 rotates a left by one (a[15] moves to bit 0). The carry flag takes the bit that wrapped round.
- R9: The zero flag is 1 exactly when the 16-bit result is 0x0000, for every opcode.
- R10: Any opcode other than the thirteen above gives result 0x0000, carry 0 and illegal-opcode 1. Every defined opcode drives illegal-opcode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 5 | Operation select |
| opnd_a | input | 16 | First operand; the only operand for unary, shift and rotate operations |
| opnd_b | input | 16 | Second operand for two-operand operations |
| result | output | 16 | Operation result |
| flag_zero | output | 1 | Result equals zero |
| flag_carry | output | 1 | Carry out, borrow, or the bit shifted out |
| op_illegal | output | 1 | Opcode is not defined |

## Verification
The zero flag and the carry flag can both be raised in the same cycle. This happens when a carry, borrow or shifted-out bit leaves an all-zero word behind. The bench provokes it on purpose with 0x8000 + 0x8000, with increment of 0xFFFF, and with a left shift of 0x8000. It also uses 0x8000 as the operand for a right rotate, which must raise carry 0 and keep zero low. Each output bundle is compared bit for bit against a reference model written in the bench. The same model judges a sweep of all 32 opcodes and a long random run.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPW = 5;

    localparam logic [OPW-1:0] OP_INC  = 5'b00111;
    localparam logic [OPW-1:0] OP_DEC  = 5'b01000;
    localparam logic [OPW-1:0] OP_AND  = 5'b01001;
    localparam logic [OPW-1:0] OP_OR   = 5'b01010;
    localparam logic [OPW-1:0] OP_XOR  = 5'b01011;
    localparam logic [OPW-1:0] OP_NOT  = 5'b01100;
    localparam logic [OPW-1:0] OP_ADD  = 5'b01101;
    localparam logic [OPW-1:0] OP_SUB  = 5'b01110;
    localparam logic [OPW-1:0] OP_CLR  = 5'b01111;
    localparam logic [OPW-1:0] OP_SHL  = 5'b10000;
    localparam logic [OPW-1:0] OP_SHR  = 5'b10001;
    localparam logic [OPW-1:0] OP_ROTR = 5'b10010;
    localparam logic [OPW-1:0] OP_ROTL = 5'b10011;

    typedef enum logic [2:0] {
        U_NONE  = 3'd0,
        U_LOGIC = 3'd1,
        U_ARITH = 3'd2,
        U_SHIFT = 3'd3,
        U_CLEAR = 3'd4
    } unit_e;

    // logic fn: 0 and, 1 or, 2 xor, 3 not
    // arith fn: 0 add, 1 sub, 2 inc, 3 dec
    // shift fn: 0 shl, 1 shr, 2 rotr, 3 rotl
    typedef struct packed {
        unit_e      unit;
        logic [1:0] fn;
    } sel_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output sel_t           sel,
    output logic           illegal
);
    always_comb begin
        sel = '{unit: U_NONE, fn: 2'd0};
        unique case (op_code)
            OP_AND:  sel = '{unit: U_LOGIC, fn: 2'd0};
            OP_OR:   sel = '{unit: U_LOGIC, fn: 2'd1};
            OP_XOR:  sel = '{unit: U_LOGIC, fn: 2'd2};
            OP_NOT:  sel = '{unit: U_LOGIC, fn: 2'd3};
            OP_ADD:  sel = '{unit: U_ARITH, fn: 2'd0};
            OP_SUB:  sel = '{unit: U_ARITH, fn: 2'd1};
            OP_INC:  sel = '{unit: U_ARITH, fn: 2'd2};
            OP_DEC:  sel = '{unit: U_ARITH, fn: 2'd3};
            OP_SHL:  sel = '{unit: U_SHIFT, fn: 2'd0};
            OP_SHR:  sel = '{unit: U_SHIFT, fn: 2'd1};
            OP_ROTR: sel = '{unit: U_SHIFT, fn: 2'd2};
            OP_ROTL: sel = '{unit: U_SHIFT, fn: 2'd3};
            OP_CLR:  sel = '{unit: U_CLEAR, fn: 2'd0};
            default: sel = '{unit: U_NONE,  fn: 2'd0};
        endcase
    end

    always_comb begin
        illegal = 1'b0;
        case (sel.unit)
            U_NONE:  illegal = 1'b1;
            default: illegal = 1'b0;
        endcase
    end

    always_comb begin
        if (op_code[OPW-1]) begin
            AST_HIGH_CODES_ARE_SHIFTS: assert (illegal || sel.unit == U_SHIFT); // R8
        end
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y,
    output logic             cy
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] rhs;
    logic             subtract;
    logic [WIDTH:0]   wide;

    always_comb begin
        rhs      = (fn[1]) ? ONE : b;
        subtract = fn[0];
        if (subtract) wide = {1'b0, a} - {1'b0, rhs};
        else          wide = {1'b0, a} + {1'b0, rhs};
        y  = wide[WIDTH-1:0];
        cy = wide[WIDTH];
    end

    always_comb begin
        if (fn == 2'd1) begin
            AST_SUB_BORROW: assert (cy == (a < b)); // R4
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (fn)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y,
    output logic             cy
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] left_v;
    logic [WIDTH-1:0] right_v;
    logic             fill_r;
    logic             fill_l;

    always_comb begin
        fill_l = fn[1] ? a[MSB] : 1'b0;
        fill_r = fn[1] ? a[0]   : 1'b0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bits
            if (gi == 0) begin : g_lo
                assign left_v[gi]  = fill_l;
                assign right_v[gi] = a[gi+1];
            end else if (gi == MSB) begin : g_hi
                assign left_v[gi]  = a[gi-1];
                assign right_v[gi] = fill_r;
            end else begin : g_mid
                assign left_v[gi]  = a[gi-1];
                assign right_v[gi] = a[gi+1];
            end
        end
    endgenerate

    always_comb begin
        unique case (fn)
            2'd0:    begin y = left_v;  cy = a[MSB]; end
            2'd1:    begin y = right_v; cy = a[0];   end
            2'd2:    begin y = right_v; cy = a[0];   end
            default: begin y = left_v;  cy = a[MSB]; end
        endcase
    end

    always_comb begin
        if (fn[1]) begin
            AST_ROTATE_KEEPS_ONES: assert ($countones(y) == $countones(a)); // R8
        end
    end
endmodule

// File: rtl/alu_shift_exec.sv
module alu_shift_exec
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [4:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             flag_zero,
    output logic             flag_carry,
    output logic             op_illegal
);
    sel_t             sel;
    logic             dec_illegal;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] shift_y;
    logic             arith_cy;
    logic             shift_cy;

    alu_decode u_decode (
        .op_code (op_code),
        .sel     (sel),
        .illegal (dec_illegal)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (sel.fn),
        .y  (logic_y)
    );

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (sel.fn),
        .y  (arith_y),
        .cy (arith_cy)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a  (opnd_a),
        .fn (sel.fn),
        .y  (shift_y),
        .cy (shift_cy)
    );

    always_comb begin
        result     = '0;
        flag_carry = 1'b0;
        unique case (sel.unit)
            U_LOGIC: begin result = logic_y; flag_carry = 1'b0;     end
            U_ARITH: begin result = arith_y; flag_carry = arith_cy; end
            U_SHIFT: begin result = shift_y; flag_carry = shift_cy; end
            U_CLEAR: begin result = '0;      flag_carry = 1'b0;     end
            default: begin result = '0;      flag_carry = 1'b0;     end
        endcase
        op_illegal = dec_illegal;
        flag_zero  = ~|result;
    end

    always_comb begin
        if (op_illegal) begin
            AST_ILLEGAL_QUIET: assert (result == '0 && !flag_carry); // R10
        end
        if (op_code == OP_ADD) begin
            AST_ADD_SUM: assert ({flag_carry, result} == {1'b0, opnd_a} + {1'b0, opnd_b}); // R3
        end
        if (op_code == OP_NOT) begin
            AST_NOT_INVERTS: assert ((result ^ opnd_a) == '1 && !flag_carry); // R2
        end
        if (op_code == OP_SHL) begin
            AST_SHL_CARRY: assert (flag_carry == opnd_a[WIDTH-1] && !result[0]); // R7
        end
        if (op_code == OP_CLR) begin
            AST_CLEAR_ZERO: assert (flag_zero && !op_illegal); // R6
        end
    end
endmodule

// File: tb/test_alu_shift_exec.sv
module test_alu_shift_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_code = 5'd0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic [15:0] result;
    logic        flag_zero, flag_carry, op_illegal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    alu_shift_exec i_alu_shift_exec (
        .op_code    (op_code),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .op_illegal (op_illegal)
    );

    // reference bundle: {illegal, zero, carry, result}
    function automatic logic [18:0] ref_model(input logic [4:0] op,
                                              input logic [15:0] a,
                                              input logic [15:0] b);
        logic [16:0] w;
        logic [15:0] r;
        logic        c;
        logic        ill;
        w = 17'd0; r = 16'd0; c = 1'b0; ill = 1'b0;
        case (op)
            5'b01001: r = a & b;
            5'b01010: r = a | b;
            5'b01011: r = a ^ b;
            5'b01100: r = ~a;
            5'b01101: begin w = a + b;          r = w[15:0]; c = w[16]; end
            5'b01110: begin r = a - b;          c = (a < b);            end
            5'b00111: begin r = a + 16'd1;      c = (a == 16'hFFFF);    end
            5'b01000: begin r = a - 16'd1;      c = (a == 16'h0000);    end
            5'b01111: r = 16'd0;
            5'b10000: begin r = a << 1;         c = a[15]; end
            5'b10001: begin r = a >> 1;         c = a[0];  end
            5'b10010: begin r = {a[0], a[15:1]}; c = a[0];  end
            5'b10011: begin r = {a[14:0], a[15]}; c = a[15]; end
            default:  ill = 1'b1;
        endcase
        return {ill, (r == 16'd0), c, r};
    endfunction

    task automatic run(input logic [4:0] op, input logic [15:0] a,
                       input logic [15:0] b, input string req);
        logic [18:0] exp;
        logic [18:0] got;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b;
        #2;
        exp = ref_model(op, a, b);
        got = {op_illegal, flag_zero, flag_carry, result};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual ill/z/c/res=%b/%b/%b/%h expected %b/%b/%b/%h",
                     req, op, a, b, got[18], got[17], got[16], got[15:0],
                     exp[18], exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic t_idle_state();
        run(5'b00000, 16'h0000, 16'h0000, "R10");
        run(5'b00000, 16'h1234, 16'h5678, "R10");
    endtask

    task automatic t_logic();
        run(5'b01001, 16'hF0F0, 16'hFF00, "R1");
        run(5'b01010, 16'hF0F0, 16'h0F0F, "R1");
        run(5'b01011, 16'hAAAA, 16'hAAAA, "R1");
        run(5'b01011, 16'h1234, 16'hFFFF, "R1");
    endtask

    task automatic t_not_ignores_b();
        run(5'b01100, 16'h00FF, 16'h0000, "R2");
        run(5'b01100, 16'h00FF, 16'hFFFF, "R2");
        run(5'b01100, 16'hFFFF, 16'h5A5A, "R2");
    endtask

    task automatic t_add_sub();
        run(5'b01101, 16'h1234, 16'h1111, "R3");
        run(5'b01101, 16'hFFFF, 16'h0002, "R3");
        run(5'b01110, 16'h0005, 16'h0003, "R4");
        run(5'b01110, 16'h0003, 16'h0005, "R4");
        run(5'b01110, 16'h7777, 16'h7777, "R4");
    endtask

    task automatic t_inc_dec();
        run(5'b00111, 16'h0041, 16'h9999, "R5");
        run(5'b00111, 16'hFFFF, 16'h0000, "R5");
        run(5'b01000, 16'h0000, 16'h0000, "R5");
        run(5'b01000, 16'h0001, 16'hFFFF, "R5");
    endtask

    task automatic t_clear();
        run(5'b01111, 16'hFFFF, 16'hFFFF, "R6");
        run(5'b01111, 16'h8001, 16'h0000, "R6");
    endtask

    task automatic t_shift();
        run(5'b10000, 16'hC001, 16'h0000, "R7");
        run(5'b10000, 16'h4000, 16'hFFFF, "R7");
        run(5'b10001, 16'h8003, 16'h0000, "R7");
        run(5'b10001, 16'h0002, 16'h0000, "R7");
    endtask

    task automatic t_rotate();
        run(5'b10010, 16'h0001, 16'h0000, "R8");
        run(5'b10010, 16'h8000, 16'h0000, "R8");
        run(5'b10011, 16'h8000, 16'h0000, "R8");
        run(5'b10011, 16'h1234, 16'h0000, "R8");
    endtask

    task automatic t_zero_with_carry();
        run(5'b01101, 16'h8000, 16'h8000, "R9");
        run(5'b00111, 16'hFFFF, 16'h0000, "R9");
        run(5'b10000, 16'h8000, 16'h0000, "R9");
        run(5'b10001, 16'h0001, 16'h0000, "R9");
        run(5'b01110, 16'h0000, 16'h0001, "R9");
    endtask

    task automatic t_opcode_sweep();
        for (int k = 0; k < 32; k++) begin
            run(5'(k), 16'hA5C3, 16'h3C5A, "R10");
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]  op;
            logic [15:0] a;
            logic [15:0] b;
            op = 5'($urandom_range(0, 31));
            a  = 16'($urandom());
            b  = 16'($urandom());
            if (k % 7 == 0) a = 16'hFFFF;
            if (k % 11 == 0) b = a;
            run(op, a, b, "R9");
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle_state();
        t_logic();
        t_not_ignores_b();
        t_add_sub();
        t_inc_dec();
        t_clear();
        t_shift();
        t_rotate();
        t_zero_with_carry();
        t_opcode_sweep();
        t_random();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule